// File: doc/BRIEF.md
# Control Setup Packet Buffer with Bus Preemption

This block holds one 8-byte control-endpoint setup packet. The USB side fills it one byte at a time and the CPU side drains it one byte at a time. A fresh setup reception always wins over the CPU: when the start of a new setup packet arrives, any CPU read still under way is cut off. Bytes the CPU asks for after that point are not delivered, and a sticky status bit records that the read was aborted.

The USB side marks each new packet with a start strobe, which restarts the fill at slot 0, and then strobes bytes in. The eighth accepted byte raises the packet-ready flag. The CPU issues read strobes. Each accepted read delivers one byte with a data-valid qualifier on the next cycle and advances a circular read pointer. The eighth read of a packet drops the ready flag. The read pointer is never rewound by a new packet. If software stops partway through a packet, every later packet is therefore read starting from the wrong slot, so software must always drain whole 8-byte units.

Top module: `setup_pkt_buf`

## Requirements
- R1: After reset, setup_valid_o, rd_abort_o and cpu_rvalid_o are 0, cpu_rdata_o is 0 and the read pointer is at slot 0.
- R2: setup_valid_o rises in the cycle after the eighth accepted byte of a packet and stays low before that byte.
- R3: An accepted read (cpu_rd_i high while setup_valid_o is high and usb_setup_start_i is low) puts the byte at the read pointer on cpu_rdata_o with cpu_rvalid_o high in the next cycle, then advances the pointer by one, modulo 8.
- R4: The eighth accepted read of a packet clears setup_valid_o in the cycle after it. While no strobe arrives, setup_valid_o holds.
- R5: A read while setup_valid_o is low yields cpu_rvalid_o = 0 and cpu_rdata_o = 0 in the next cycle and leaves the read pointer unchanged. In any cycle without a delivered byte, cpu_rdata_o is 0.
- R6: usb_setup_start_i clears setup_valid_o in the next cycle and restarts filling at slot 0.
- R7: rd_abort_o is set in the next cycle when usb_setup_start_i arrives while setup_valid_o is high and either at least one byte of the packet has been read or a read strobe is present in the same cycle. A start with setup_valid_o low leaves it unchanged.
- R8: rd_abort_o stays set until cpu_abort_clr_i is pulsed, and it clears in the cycle after that pulse when no new abort condition is present.
- R9: A read strobe in the same cycle as usb_setup_start_i delivers nothing (cpu_rvalid_o = 0 in the next cycle).
- R10: usb_setup_start_i does not move the read pointer. After a partial read of k bytes, the first read of the next packet returns slot k.
- R11: Byte strobes after the eighth byte and before the next start are ignored and alter no slot.
- R12: A byte strobed in the same cycle as usb_setup_start_i is stored in slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_setup_start_i | input | 1 | Start of a new setup packet from the bus |
| usb_byte_we_i | input | 1 | Byte strobe from the bus |
| usb_byte_i | input | 8 | Byte from the bus |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_abort_clr_i | input | 1 | Write-1-to-clear pulse for the abort flag |
| cpu_rdata_o | output | 8 | Delivered byte (0 when none) |
| cpu_rvalid_o | output | 1 | cpu_rdata_o carries a delivered byte |
| setup_valid_o | output | 1 | A complete packet is ready for reading |
| rd_abort_o | output | 1 | Sticky: a CPU read was cut off by a new packet |

## Verification
The properties assume that all inputs are held at 0 during reset, so that the first `$past` sample after reset sees idle strobes. They also assume that strobes are single-cycle levels that are sampled only at the clock edge. The stimulus drives every input on the falling edge and returns all of them to 0 at reset. The vectors deliberately combine a start strobe with byte and read strobes in the same cycle, because the preemption rules are defined for exactly those collisions.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int unsigned SBUF_DW    = 8;
    localparam int unsigned SBUF_DEPTH = 8;
endpackage

// File: rtl/sbuf_wr_ctrl.sv
module sbuf_wr_ctrl #(
    parameter int unsigned DEPTH = sbuf_pkg::SBUF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sof_i,
    input  logic                     we_i,
    output logic                     wr_en_o,
    output logic [$clog2(DEPTH)-1:0] wr_idx_o,
    output logic                     pkt_done_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q, base;

    always_comb begin
        base       = sof_i ? '0 : cnt_q;
        wr_en_o    = we_i && (base < CNT_W'(DEPTH));
        wr_idx_o   = base[PTR_W-1:0];
        pkt_done_o = wr_en_o && (base == CNT_W'(DEPTH - 1));
        cnt_d      = wr_en_o ? base + 1'b1 : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
    parameter int unsigned DW    = sbuf_pkg::SBUF_DW,
    parameter int unsigned DEPTH = sbuf_pkg::SBUF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
    input  logic [DW-1:0]            wr_data_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [DW-1:0]            rd_data_o
);
    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en_i && (wr_idx_i == g[$clog2(DEPTH)-1:0])) slot_d = wr_data_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/sbuf_rd_ctrl.sv
module sbuf_rd_ctrl #(
    parameter int unsigned DW    = sbuf_pkg::SBUF_DW,
    parameter int unsigned DEPTH = sbuf_pkg::SBUF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sof_i,
    input  logic                     rd_i,
    input  logic                     clr_i,
    input  logic                     pkt_done_i,
    input  logic [DW-1:0]            slot_data_i,
    output logic [$clog2(DEPTH)-1:0] rd_idx_o,
    output logic                     valid_o,
    output logic                     abort_o,
    output logic                     rvalid_o,
    output logic [DW-1:0]            rdata_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] rcnt;
        logic             valid;
        logic             abort;
        logic             rvalid;
        logic [DW-1:0]    rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      take;

    always_comb begin
        st_d = st_q;
        take = rd_i && st_q.valid && !sof_i;

        st_d.rvalid = take;
        st_d.rdata  = take ? slot_data_i : '0;
        if (take) begin
            st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
            st_d.rcnt = st_q.rcnt + 1'b1;
            if (st_q.rcnt == CNT_W'(DEPTH - 1)) st_d.valid = 1'b0;
        end
        if (sof_i) st_d.valid = 1'b0;
        if (pkt_done_i) begin
            st_d.valid = 1'b1;
            st_d.rcnt  = '0;
        end

        if (sof_i && st_q.valid && ((st_q.rcnt != '0) || rd_i)) st_d.abort = 1'b1;
        else if (clr_i)                                         st_d.abort = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_idx_o = st_q.rptr;
    assign valid_o  = st_q.valid;
    assign abort_o  = st_q.abort;
    assign rvalid_o = st_q.rvalid;
    assign rdata_o  = st_q.rdata;
endmodule

// File: rtl/setup_pkt_buf.sv
module setup_pkt_buf #(
    parameter int unsigned DW    = sbuf_pkg::SBUF_DW,
    parameter int unsigned DEPTH = sbuf_pkg::SBUF_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usb_setup_start_i,
    input  logic          usb_byte_we_i,
    input  logic [DW-1:0] usb_byte_i,
    input  logic          cpu_rd_i,
    input  logic          cpu_abort_clr_i,
    output logic [DW-1:0] cpu_rdata_o,
    output logic          cpu_rvalid_o,
    output logic          setup_valid_o,
    output logic          rd_abort_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic             wr_en, pkt_done;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [DW-1:0]    slot_data;

    sbuf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n), .sof_i(usb_setup_start_i), .we_i(usb_byte_we_i),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .pkt_done_o(pkt_done)
    );

    sbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(usb_byte_i), .rd_idx_i(rd_idx), .rd_data_o(slot_data)
    );

    sbuf_rd_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .sof_i(usb_setup_start_i), .rd_i(cpu_rd_i),
        .clr_i(cpu_abort_clr_i), .pkt_done_i(pkt_done), .slot_data_i(slot_data),
        .rd_idx_o(rd_idx), .valid_o(setup_valid_o), .abort_o(rd_abort_o),
        .rvalid_o(cpu_rvalid_o), .rdata_o(cpu_rdata_o)
    );
endmodule

// File: rtl/setup_pkt_buf_chk.sv
module setup_pkt_buf_chk #(
    parameter int unsigned DW = sbuf_pkg::SBUF_DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          usb_setup_start_i,
    input logic          usb_byte_we_i,
    input logic [DW-1:0] usb_byte_i,
    input logic          cpu_rd_i,
    input logic          cpu_abort_clr_i,
    input logic [DW-1:0] cpu_rdata_o,
    input logic          cpu_rvalid_o,
    input logic          setup_valid_o,
    input logic          rd_abort_o
);
    a_r2_valid_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_valid_o) |-> $past(usb_byte_we_i));

    a_r4_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid_o && !usb_setup_start_i && !usb_byte_we_i && !cpu_rd_i) |=> setup_valid_o);

    a_r5_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && !setup_valid_o) |=> (!cpu_rvalid_o && cpu_rdata_o == '0));

    a_r6_start_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        usb_setup_start_i |=> !setup_valid_o);

    a_r7_abort_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_abort_o) |-> $past(usb_setup_start_i));

    a_r8_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_abort_o && !cpu_abort_clr_i) |=> rd_abort_o);

    a_r8_abort_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_abort_clr_i && !usb_setup_start_i) |=> !rd_abort_o);

    a_r9_start_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        usb_setup_start_i |=> !cpu_rvalid_o);
endmodule

bind setup_pkt_buf setup_pkt_buf_chk u_chk (.*);

// File: tb/setup_pkt_buf_tb.sv
module setup_pkt_buf_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sof = 1'b0, we = 1'b0, rd = 1'b0, clr = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] rdata;
    logic       rvalid, valid, abort;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    setup_pkt_buf u_dut (
        .clk(clk), .rst_n(rst_n), .usb_setup_start_i(sof), .usb_byte_we_i(we),
        .usb_byte_i(din), .cpu_rd_i(rd), .cpu_abort_clr_i(clr),
        .cpu_rdata_o(rdata), .cpu_rvalid_o(rvalid), .setup_valid_o(valid), .rd_abort_o(abort)
    );

    // {req, sof, we, data, rd, clr, exp_valid, exp_rvalid, exp_rdata, exp_abort}
    localparam int NV = 43;
    localparam logic [26:0] VEC [NV] = '{
        {4'd12,1'b1,1'b1,8'h10,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h11,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h12,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h13,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h14,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h15,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h16,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h17,1'b0,1'b0, 1'b1,1'b0,8'h00,1'b0},
        {4'd3, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h10,1'b0},
        {4'd3, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h11,1'b0},
        {4'd5, 1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,1'b0,8'h00,1'b0},
        {4'd7, 1'b1,1'b1,8'h20,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b1},
        {4'd5, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,8'h00,1'b1},
        {4'd8, 1'b0,1'b0,8'h00,1'b0,1'b1, 1'b0,1'b0,8'h00,1'b0},
        {4'd6, 1'b0,1'b1,8'h21,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd6, 1'b0,1'b1,8'h22,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd6, 1'b0,1'b1,8'h23,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd6, 1'b0,1'b1,8'h24,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd6, 1'b0,1'b1,8'h25,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd6, 1'b0,1'b1,8'h26,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h27,1'b0,1'b0, 1'b1,1'b0,8'h00,1'b0},
        {4'd10,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h22,1'b0},
        {4'd9, 1'b1,1'b1,8'h30,1'b1,1'b0, 1'b0,1'b0,8'h00,1'b1},
        {4'd8, 1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b1},
        {4'd8, 1'b0,1'b0,8'h00,1'b0,1'b1, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h31,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h32,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h33,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h34,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h35,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h36,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd2, 1'b0,1'b1,8'h37,1'b0,1'b0, 1'b1,1'b0,8'h00,1'b0},
        {4'd11,1'b0,1'b1,8'h99,1'b0,1'b0, 1'b1,1'b0,8'h00,1'b0},
        {4'd3, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h33,1'b0},
        {4'd3, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h34,1'b0},
        {4'd3, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h35,1'b0},
        {4'd3, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h36,1'b0},
        {4'd3, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h37,1'b0},
        {4'd12,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h30,1'b0},
        {4'd10,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,8'h31,1'b0},
        {4'd4, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b1,8'h32,1'b0},
        {4'd5, 1'b0,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,8'h00,1'b0},
        {4'd7, 1'b1,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0}
    };

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";   4'd2:  return "R2";   4'd3:  return "R3";
            4'd4:  return "R4";   4'd5:  return "R5";   4'd6:  return "R6";
            4'd7:  return "R7";   4'd8:  return "R8";   4'd9:  return "R9";
            4'd10: return "R10";  4'd11: return "R11";  4'd12: return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic step(input logic s, input logic w, input logic [7:0] d,
                        input logic r, input logic c);
        @(negedge clk);
        sof = s; we = w; din = d; rd = r; clr = c;
        @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string tag, input logic ev, input logic erv,
                              input logic [7:0] ed, input logic eab);
        n_chk++;
        if (valid !== ev || rvalid !== erv || rdata !== ed || abort !== eab) begin
            n_bad++;
            $display("FAIL %s: valid/rvalid/rdata/abort = %b/%b/%h/%b, expected %b/%b/%h/%b",
                     tag, valid, rvalid, rdata, abort, ev, erv, ed, eab);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        expect_out("R1 in reset", 1'b0, 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][22], VEC[i][21], VEC[i][20:13], VEC[i][12], VEC[i][11]);
            expect_out($sformatf("%s vector %0d", rtag(VEC[i][26:23]), i),
                       VEC[i][10], VEC[i][9], VEC[i][8:1], VEC[i][0]);
        end

        // R1: reset returns the read pointer to slot 0 and clears all flags
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b0;
        #2;
        expect_out("R1 after reset", 1'b0, 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 / R4: aligned whole-packet drain returns bytes in written order
        for (int k = 0; k < 8; k++) begin
            step(k == 0, 1'b1, 8'hA0 + 8'(k), 1'b0, 1'b0);
            expect_out("R2 directed fill", k == 7, 1'b0, 8'h00, 1'b0);
        end
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
            expect_out(k == 7 ? "R4 last read" : "R3 in-order read",
                       k != 7, 1'b1, 8'hA0 + 8'(k), 1'b0);
        end
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        expect_out("R5 idle after drain", 1'b0, 1'b0, 8'h00, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule